// File: doc/BRIEF.md
# Scheduler-Gated Descriptor Copy Engine

This block moves packet data out of a bridge-local RAM into host main memory, one word per clock. Driver software supplies work through two queues. The source queue holds a local start address and a length in words. The destination queue holds a host start address only. The k-th source entry is always paired with the k-th destination entry. The engine raises `data_rdy` while any source entry is queued, so that an external bandwidth scheduler can see that the port has traffic. The scheduler grants bus time by holding `block` low.

Both queue heads stay in place until their packet has been fully copied. Only then are they retired together, and a record of the finished transfer is written to a completion queue that software drains. Interrupts are coalesced. A pulse is raised once enough completions have built up, or once a timeout has run out after the first completion that has not yet been reported.

Top module: `dmab_engine`

## Requirements
- R1: While reset is asserted and right after it, `host_we`, `irq`, `data_rdy` and `cpl_valid` are low.
- R2: `data_rdy` is high exactly when the source queue holds at least one entry, whether or not a destination is available.
- R3: For a packet with local address S, host address D and length L words, word i (0 <= i < L) is written to host address D+i with the data read from local address S+i. At most one word is written per cycle.
- R4: `host_we` is never high in a cycle where `block` is high. A packet interrupted by `block` resumes at the offset where it stopped, and its final host contents are exact.
- R5: No transfer begins unless both queues are non-empty. With the destination queue empty, no word is written.
- R6: Both queue heads are removed in the same cycle as the last word of their packet. Packets complete in push order.
- R7: A source entry with length 0 is retired with its destination and produces a completion record, with no host write.
- R8: Each finished packet pushes a record holding {local address, host address, length}. `cpl_valid` shows the oldest record, and `cpl_pop` removes it.
- R9: When the count of unreported completions reaches `cfg_thresh` (0 acts as 1), `irq` pulses high for one cycle and the count clears.
- R10: With `cfg_timeout` nonzero, if the threshold is not reached, `irq` rises exactly `cfg_timeout` cycles after the record of the first unreported completion becomes visible on an empty completion queue. A value of 0 disables the timeout.
- R11: No transfer starts while the completion queue is full. Copying resumes after a record is popped.
- R12: A push into a full source or destination queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_push | input | 1 | Push a source entry |
| src_addr_in | input | AW | Local start address of the entry |
| src_len_in | input | LW | Packet length in words |
| src_full | output | 1 | Source queue full |
| dst_push | input | 1 | Push a destination entry |
| dst_addr_in | input | AW | Host start address of the entry |
| dst_full | output | 1 | Destination queue full |
| block | input | 1 | Scheduler hold; no data moves while high |
| data_rdy | output | 1 | A source entry is waiting |
| lram_addr | output | AW | Local RAM read address |
| lram_rdata | input | DW | Local RAM read data, same cycle |
| host_we | output | 1 | Host memory write strobe |
| host_addr | output | AW | Host memory write address |
| host_wdata | output | DW | Host memory write data |
| cfg_thresh | input | CW | Completions per interrupt |
| cfg_timeout | input | TW | Coalescing timeout in cycles, 0 = off |
| irq | output | 1 | One-cycle interrupt pulse |
| cpl_pop | input | 1 | Remove the oldest completion record |
| cpl_valid | output | 1 | A completion record is available |
| cpl_src | output | AW | Record: local address |
| cpl_dst | output | AW | Record: host address |
| cpl_len | output | LW | Record: length |

## Verification
A wrong copy offset or a queue pointer that slips shows up at the ports almost at once. Host memory gets a wrong word in the same cycle as the bad write, and the completion record (or its pairing with the destination) is wrong when the packet retires. A scheduler hold that is ignored appears as a write strobe while `block` is high, in that very cycle. A lost resume position leaves holes or shifted words that show after the last word of the packet. A coalescing counter or timer that is off shows as a pulse on the wrong cycle, or a missing pulse, counted from the completion that began the batch.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    localparam int DEF_AW     = 10;
    localparam int DEF_DW     = 32;
    localparam int DEF_LW     = 6;
    localparam int DEF_QDEPTH = 4;
    localparam int DEF_CDEPTH = 4;
    localparam int DEF_CW     = 4;
    localparam int DEF_TW     = 8;

    // zero threshold behaves as one completion per interrupt
    function automatic logic [DEF_CW-1:0] eff_thresh(input logic [DEF_CW-1:0] t);
        return (t == '0) ? DEF_CW'(1) : t;
    endfunction
endpackage

// File: rtl/dmab_fifo.sv
module dmab_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= din;
    end

    assign dout  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R12: a push into a full queue leaves the occupancy unchanged
    a_r12_push_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> st_q.cnt == $past(st_q.cnt));
endmodule

// File: rtl/dmab_irq_coal.sv
module dmab_irq_coal #(
    parameter int CW = dmab_pkg::DEF_CW,
    parameter int TW = dmab_pkg::DEF_TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [CW-1:0] thresh,
    input  logic [TW-1:0] timeout,
    output logic          irq
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] tmr;
        logic          irq;
    } coal_st_t;

    coal_st_t st_d, st_q;
    logic [CW-1:0] th, cnt_next;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        th       = (thresh == '0) ? CW'(1) : thresh;
        cnt_next = st_q.cnt + CW'(evt);
        if (evt && cnt_next >= th) begin
            st_d.irq = 1'b1;
            st_d.cnt = '0;
            st_d.tmr = '0;
        end else begin
            st_d.cnt = cnt_next;
            if (st_q.cnt == '0) begin
                st_d.tmr = '0;
            end else if (timeout != '0) begin
                if (TW'(st_q.tmr + 1'b1) == timeout) begin
                    st_d.irq = 1'b1;
                    st_d.cnt = '0;
                    st_d.tmr = '0;
                end else begin
                    st_d.tmr = st_q.tmr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R9: every interrupt leaves the unreported count cleared
    a_r9_irq_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.cnt == '0);
    // R10: the timer is idle whenever nothing is pending
    a_r10_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt == '0 |-> st_q.tmr == '0);
endmodule

// File: rtl/dmab_engine.sv
module dmab_engine #(
    parameter int AW     = dmab_pkg::DEF_AW,
    parameter int DW     = dmab_pkg::DEF_DW,
    parameter int LW     = dmab_pkg::DEF_LW,
    parameter int QDEPTH = dmab_pkg::DEF_QDEPTH,
    parameter int CDEPTH = dmab_pkg::DEF_CDEPTH,
    parameter int CW     = dmab_pkg::DEF_CW,
    parameter int TW     = dmab_pkg::DEF_TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_push,
    input  logic [AW-1:0] src_addr_in,
    input  logic [LW-1:0] src_len_in,
    output logic          src_full,
    input  logic          dst_push,
    input  logic [AW-1:0] dst_addr_in,
    output logic          dst_full,
    input  logic          block,
    output logic          data_rdy,
    output logic [AW-1:0] lram_addr,
    input  logic [DW-1:0] lram_rdata,
    output logic          host_we,
    output logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_wdata,
    input  logic [CW-1:0] cfg_thresh,
    input  logic [TW-1:0] cfg_timeout,
    output logic          irq,
    input  logic          cpl_pop,
    output logic          cpl_valid,
    output logic [AW-1:0] cpl_src,
    output logic [AW-1:0] cpl_dst,
    output logic [LW-1:0] cpl_len
);
    localparam int SW = AW + LW;
    localparam int RW = 2 * AW + LW;

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] off;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [SW-1:0] src_dout;
    logic [AW-1:0] dst_dout;
    logic [RW-1:0] cpl_dout;
    logic          src_empty, dst_empty, cpl_empty, cpl_full;
    logic [AW-1:0] head_src, head_dst;
    logic [LW-1:0] head_len;
    logic          can_start, last_word, retire;

    dmab_fifo #(.W(SW), .DEPTH(QDEPTH)) u_src_q (
        .clk(clk), .rst_n(rst_n), .push(src_push), .din({src_addr_in, src_len_in}),
        .pop(retire), .dout(src_dout), .empty(src_empty), .full(src_full));

    dmab_fifo #(.W(AW), .DEPTH(QDEPTH)) u_dst_q (
        .clk(clk), .rst_n(rst_n), .push(dst_push), .din(dst_addr_in),
        .pop(retire), .dout(dst_dout), .empty(dst_empty), .full(dst_full));

    dmab_fifo #(.W(RW), .DEPTH(CDEPTH)) u_cpl_q (
        .clk(clk), .rst_n(rst_n), .push(retire), .din({head_src, head_dst, head_len}),
        .pop(cpl_pop), .dout(cpl_dout), .empty(cpl_empty), .full(cpl_full));

    dmab_irq_coal #(.CW(CW), .TW(TW)) u_coal (
        .clk(clk), .rst_n(rst_n), .evt(retire), .thresh(cfg_thresh),
        .timeout(cfg_timeout), .irq(irq));

    assign head_src = src_dout[SW-1:LW];
    assign head_len = src_dout[LW-1:0];
    assign head_dst = dst_dout;

    always_comb begin
        st_d      = st_q;
        can_start = !st_q.busy && !src_empty && !dst_empty && !cpl_full;
        host_we   = st_q.busy && !block;
        last_word = host_we && (st_q.off == head_len - 1'b1);
        retire    = last_word || (can_start && head_len == '0);
        if (can_start && head_len != '0) begin
            st_d.busy = 1'b1;
            st_d.off  = '0;
        end
        if (host_we) begin
            st_d.off = st_q.off + 1'b1;
            if (last_word) begin
                st_d.busy = 1'b0;
                st_d.off  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lram_addr  = head_src + AW'(st_q.off);
    assign host_addr  = head_dst + AW'(st_q.off);
    assign host_wdata = lram_rdata;
    assign data_rdy   = !src_empty;
    assign cpl_valid  = !cpl_empty;
    assign cpl_src    = cpl_dout[RW-1 -: AW];
    assign cpl_dst    = cpl_dout[AW+LW-1 -: AW];
    assign cpl_len    = cpl_dout[LW-1:0];

    // R3: the running offset stays inside the head packet
    a_r3_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.off < head_len);
    // R5: a write happens only with both queue heads present
    a_r5_write_needs_heads: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> !src_empty && !dst_empty);
    // R4: a held packet keeps its offset
    a_r4_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && block |=> st_q.busy && st_q.off == $past(st_q.off));
    // R11: a record is never pushed into a full completion queue
    a_r11_no_cpl_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> !cpl_full);
endmodule

// File: tb/dmab_engine_bench.sv
module dmab_engine_bench;
    localparam int AW = 10, DW = 32, LW = 6, CW = 4, TW = 8, QD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic src_push = 0, dst_push = 0, block = 0, cpl_pop = 0;
    logic [AW-1:0] src_addr_in = '0, dst_addr_in = '0;
    logic [LW-1:0] src_len_in = '0;
    logic [CW-1:0] cfg_thresh = CW'(1);
    logic [TW-1:0] cfg_timeout = '0;
    logic src_full, dst_full, data_rdy, host_we, irq, cpl_valid;
    logic [AW-1:0] lram_addr, host_addr, cpl_src, cpl_dst;
    logic [DW-1:0] lram_rdata, host_wdata;
    logic [LW-1:0] cpl_len;

    int checks = 0, fails = 0, wr_cnt = 0, irq_cnt = 0, viol = 0, cyc = 0;
    bit done = 0;
    logic [DW-1:0] hmem [1024];

    always #2 clk = ~clk;

    dmab_engine u_dmab_engine (
        .clk(clk), .rst_n(rst_n), .src_push(src_push), .src_addr_in(src_addr_in),
        .src_len_in(src_len_in), .src_full(src_full), .dst_push(dst_push),
        .dst_addr_in(dst_addr_in), .dst_full(dst_full), .block(block), .data_rdy(data_rdy),
        .lram_addr(lram_addr), .lram_rdata(lram_rdata), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .cfg_thresh(cfg_thresh),
        .cfg_timeout(cfg_timeout), .irq(irq), .cpl_pop(cpl_pop), .cpl_valid(cpl_valid),
        .cpl_src(cpl_src), .cpl_dst(cpl_dst), .cpl_len(cpl_len));

    function automatic logic [DW-1:0] pat(input int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    assign lram_rdata = pat(int'(lram_addr));

    always @(posedge clk) begin
        if (host_we) begin
            hmem[host_addr] <= host_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (host_we && block) viol <= viol + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end
    always @(negedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic push_src(input int a, input int l);
        @(negedge clk); src_push = 1; src_addr_in = AW'(a); src_len_in = LW'(l);
        @(negedge clk); src_push = 0;
    endtask

    task automatic push_dst(input int a);
        @(negedge clk); dst_push = 1; dst_addr_in = AW'(a);
        @(negedge clk); dst_push = 0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // compare the oldest record, then remove it
    task automatic pop_rec(input string req, input int s, input int d, input int l);
        @(negedge clk);
        chk(cpl_valid, req, cpl_valid, 1);
        chk(cpl_src == AW'(s) && cpl_dst == AW'(d) && cpl_len == LW'(l), req,
            {cpl_src, cpl_dst, cpl_len}, {AW'(s), AW'(d), LW'(l)});
        cpl_pop = 1;
        @(negedge clk); cpl_pop = 0;
    endtask

    task automatic chk_copy(input string req, input int s, input int d, input int l);
        int bad = 0;
        for (int i = 0; i < l; i++) if (hmem[d+i] !== pat(s+i)) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        int w0, i0, t0, t1, s, d, l;
        bit rnd_on;
        for (int i = 0; i < 1024; i++) hmem[i] = 32'hDEAD_BEEF;
        void'($urandom(32'd20240607));
        waitn(1);
        // R1: reset values
        chk(!host_we && !irq && !data_rdy && !cpl_valid, "R1", {host_we, irq, data_rdy, cpl_valid}, 0);
        waitn(2); rst_n = 1; waitn(1);
        chk(!host_we && !irq && !data_rdy && !cpl_valid, "R1", {host_we, irq, data_rdy, cpl_valid}, 0);

        // R5 / R2: source without destination
        push_src(100, 5); waitn(10);
        chk(data_rdy, "R2", data_rdy, 1);
        chk(wr_cnt == 0, "R5", wr_cnt, 0);
        push_dst(600); waitn(12);
        chk_copy("R3", 100, 600, 5);
        chk(wr_cnt == 5, "R3", wr_cnt, 5);
        chk(!data_rdy, "R6", data_rdy, 0);
        chk(irq_cnt == 1, "R9", irq_cnt, 1);
        pop_rec("R8", 100, 600, 5);

        // R7: zero length
        w0 = wr_cnt;
        push_src(200, 0); push_dst(700); waitn(6);
        chk(wr_cnt == w0 && hmem[700] == 32'hDEAD_BEEF, "R7", wr_cnt, w0);
        pop_rec("R7", 200, 700, 0);

        // R4: directed hold and resume
        block = 1;
        push_src(300, 8); push_dst(800); waitn(15);
        chk(wr_cnt == w0, "R4", wr_cnt, w0);
        chk(data_rdy, "R2", data_rdy, 1);
        block = 0; waitn(3); block = 1; waitn(8);
        chk(wr_cnt == w0 + 3, "R4", wr_cnt, w0 + 3);
        block = 0; waitn(10);
        chk_copy("R4", 300, 800, 8);
        pop_rec("R6", 300, 800, 8);

        // R12 + R9: overfill source queue, threshold of two
        cfg_thresh = CW'(2); i0 = irq_cnt;
        for (int k = 0; k < QD + 2; k++) push_src(400 + 10 * k, 2);
        chk(src_full, "R12", src_full, 1);
        for (int k = 0; k < QD; k++) push_dst(850 + 4 * k);
        waitn(20);
        chk(!data_rdy, "R12", data_rdy, 0);
        chk(irq_cnt == i0 + 2, "R9", irq_cnt, i0 + 2);
        for (int k = 0; k < QD; k++) pop_rec("R6", 400 + 10 * k, 850 + 4 * k, 2);
        waitn(4);
        chk(!cpl_valid, "R12", cpl_valid, 0);

        // R10: timeout after first unreported completion
        cfg_thresh = CW'(8); cfg_timeout = TW'(20); i0 = irq_cnt;
        push_src(500, 3); push_dst(900);
        wait (cpl_valid); t0 = cyc;
        wait (irq); t1 = cyc;
        chk(t1 - t0 == 20, "R10", t1 - t0, 20);
        waitn(3);
        chk(irq_cnt == i0 + 1, "R10", irq_cnt, i0 + 1);
        pop_rec("R8", 500, 900, 3);

        // R11: completion queue full stalls copying
        cfg_timeout = '0; cfg_thresh = CW'(1);
        for (int k = 0; k < 4; k++) begin push_src(10 + 4 * k, 2); push_dst(940 + 2 * k); end
        waitn(10);
        w0 = wr_cnt;
        push_src(60, 2); push_dst(960); waitn(15);
        chk(wr_cnt == w0 && hmem[960] == 32'hDEAD_BEEF, "R11", wr_cnt, w0);
        chk(data_rdy, "R11", data_rdy, 1);
        for (int k = 0; k < 4; k++) pop_rec("R11", 10 + 4 * k, 940 + 2 * k, 2);
        waitn(8);
        chk_copy("R11", 60, 960, 2);
        pop_rec("R11", 60, 960, 2);

        // random packets with random scheduler holds
        rnd_on = 1;
        fork
            while (rnd_on) begin
                @(negedge clk);
                block = ($urandom % 3) == 0;
            end
        join_none
        for (int p = 0; p < 30; p++) begin
            l = 1 + int'($urandom % 20);
            s = int'($urandom % 500);
            d = 512 + int'($urandom % (500 - l));
            push_src(s, l); push_dst(d);
            wait (cpl_valid);
            waitn(1);
            chk_copy("R3", s, d, l);
            pop_rec("R8", s, d, l);
        end
        rnd_on = 0; waitn(2); block = 0;
        chk(viol == 0, "R4", viol, 0);
        done = 1;
        summary();
    end
endmodule